// File: doc/BRIEF.md
# Atomic Coefficient Staging Loader

This block sits behind the byte-level slave of a serial control bus and collects filter coefficient updates for a signal processor. A transfer opens with a start indication. The first bytes of the transfer form a coefficient RAM start address, most significant byte first. The bytes after that are grouped into fixed-width coefficients, also most significant byte first. Each complete coefficient goes into a small holding buffer. The block decides per byte whether to acknowledge it, and it touches the coefficient RAM only once the transfer has ended.

When a stop or a repeated start closes the transfer, a copy engine writes the coefficients that transfer delivered into the RAM. It writes one entry per clock at consecutive addresses and raises a busy flag while it does so. The processing datapath therefore always sees either the old coefficient set or the complete new one. Bytes beyond the buffer capacity are refused and the data already held is kept. A transfer whose bytes collide with a copy in progress is refused as a whole.

Top module: `coef_stage_loader`

## Requirements
- R1: After a start, the first ceil(ADDR_W/BYTE_W) accepted bytes form the start address, most significant byte first, keeping the low ADDR_W bits. Every following group of BYTES_PER_COEF bytes forms one coefficient, most significant byte first. The buffer holds at most DEPTH coefficients.
- R2: Every byte the buffer can take is answered one clock after its byte_valid cycle with ack_valid=1 and ack_ok=1 (1 means ACK, 0 means NACK).
- R3: Inside a transfer, the data byte after the first DEPTH*BYTES_PER_COEF data bytes gets ack_ok=0, and so does every later byte of that transfer.
- R4: An overflow leaves the held coefficients unchanged, and the closing commit still writes all DEPTH of them with their original values.
- R5: No RAM write occurs while a transfer is open. A stop or a repeated start closes the transfer and starts the commit.
- R6: A commit writes only the complete coefficients of the transfer just closed. A trailing partial coefficient is dropped, entries left over from earlier transfers are never written again, and a transfer with no complete coefficient writes nothing.
- R7: Entry i is written to start address + i, modulo 2^ADDR_W, with no range check.
- R8: The first write appears in the clock right after the closing edge. Writes follow one per clock, and busy is high for exactly as many cycles as writes occur.
- R9: A byte that arrives while busy is high gets ack_ok=0. Every later byte of that transfer also gets ack_ok=0, and the transfer commits nothing.
- R10: A byte received outside a transfer (after reset or after a stop, before the next start) gets ack_ok=0 and has no effect on later commits.
- R11: After reset, busy, ram_we and ack_valid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_start | input | 1 | One-cycle pulse: start or repeated start seen |
| bus_stop | input | 1 | One-cycle pulse: stop seen |
| byte_valid | input | 1 | One-cycle pulse: a received byte is on byte_data |
| byte_data | input | BYTE_W | Received byte |
| ack_valid | output | 1 | Acknowledge decision valid (one cycle after byte_valid) |
| ack_ok | output | 1 | 1 = ACK, 0 = NACK |
| busy | output | 1 | Commit copy in progress |
| ram_we | output | 1 | Coefficient RAM write enable |
| ram_addr | output | ADDR_W | Coefficient RAM write address |
| ram_wdata | output | BYTE_W*BYTES_PER_COEF | Coefficient RAM write data |

## Verification
The bench builds the block with DEPTH=4, BYTES_PER_COEF=2 and ADDR_W=10. With these values the capacity is reached after eight data bytes, so the overflow can be tested in a short sequence. The address still spans two bytes, which puts the wrap from 0x3FF to 0x000 within reach. The four-cycle commit is long enough for a byte to arrive while busy is high. Directed scenarios cover a stray byte, a plain update, overflow, a repeated start that collides with its own commit, partial and empty transfers, and address wrap.

// File: rtl/coef_ld_pkg.sv
package coef_ld_pkg;
   typedef enum logic [2:0] {
      PH_IDLE,
      PH_ADDR,
      PH_DATA,
      PH_FULL,
      PH_BLOCK
   } phase_t;

   function automatic int bytes_for(input int bits, input int byte_w);
      return (bits + byte_w - 1) / byte_w;
   endfunction
endpackage

// File: rtl/csl_rx_ctrl.sv
module csl_rx_ctrl
   import coef_ld_pkg::*;
#(
   parameter int BYTE_W = 8,
   parameter int ADDR_W = 10,
   parameter int BPC    = 3,
   parameter int DEPTH  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_start,
   input  logic              bus_stop,
   input  logic              byte_valid,
   input  logic [BYTE_W-1:0] byte_data,
   input  logic              busy,
   output logic              ack_valid,
   output logic              ack_ok,
   output logic              data_stb,
   output logic              clr,
   output logic              commit_req,
   output logic [ADDR_W-1:0] base_addr
);
   localparam int ADDR_BYTES = bytes_for(ADDR_W, BYTE_W);
   localparam int CAP        = DEPTH * BPC;
   localparam int DC_W       = $clog2(CAP + 1);
   localparam int AC_W       = $clog2(ADDR_BYTES + 1);

   phase_t            phase_q, phase_d;
   logic [ADDR_W-1:0] addr_q;
   logic [AC_W-1:0]   acnt_q;
   logic [DC_W-1:0]   dcnt_q;
   logic              take;

   always_comb begin
      phase_d  = phase_q;
      take     = 1'b0;
      data_stb = 1'b0;
      if (bus_start) begin
         phase_d = PH_ADDR;
      end else if (bus_stop) begin
         phase_d = PH_IDLE;
      end else if (byte_valid) begin
         case (phase_q)
            PH_ADDR: begin
               if (busy) begin
                  phase_d = PH_BLOCK;
               end else begin
                  take = 1'b1;
                  if (acnt_q == AC_W'(ADDR_BYTES - 1)) phase_d = PH_DATA;
               end
            end
            PH_DATA: begin
               if (busy) begin
                  phase_d = PH_BLOCK;
               end else if (dcnt_q == DC_W'(CAP)) begin
                  phase_d = PH_FULL;
               end else begin
                  take     = 1'b1;
                  data_stb = 1'b1;
               end
            end
            default: ;
         endcase
      end
   end

   assign clr        = bus_start;
   assign commit_req = (bus_start || bus_stop) &&
                       (phase_q == PH_DATA || phase_q == PH_FULL);
   assign base_addr  = addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q   <= PH_IDLE;
         addr_q    <= '0;
         acnt_q    <= '0;
         dcnt_q    <= '0;
         ack_valid <= 1'b0;
         ack_ok    <= 1'b0;
      end else begin
         phase_q   <= phase_d;
         ack_valid <= byte_valid;
         ack_ok    <= byte_valid && take;
         if (bus_start) begin
            acnt_q <= '0;
            dcnt_q <= '0;
         end else if (take) begin
            if (phase_q == PH_ADDR) begin
               addr_q <= ADDR_W'({addr_q, byte_data});
               acnt_q <= acnt_q + 1'b1;
            end else begin
               dcnt_q <= dcnt_q + 1'b1;
            end
         end
      end
   end

   // R3
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      byte_valid && !bus_start && !bus_stop && phase_q == PH_FULL |=> ack_valid && !ack_ok)
      else $error("byte after overflow was acknowledged");

   // R10
   idle_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      byte_valid && !bus_start && !bus_stop && phase_q == PH_IDLE |=> ack_valid && !ack_ok)
      else $error("byte outside a transfer was acknowledged");

   // R9
   busy_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      byte_valid && busy && !bus_start && !bus_stop |=> !ack_ok)
      else $error("byte during commit was acknowledged");
endmodule

// File: rtl/csl_word_pack.sv
module csl_word_pack #(
   parameter int BYTE_W = 8,
   parameter int BPC    = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  clr,
   input  logic                  stb,
   input  logic [BYTE_W-1:0]     din,
   output logic                  word_valid,
   output logic [BYTE_W*BPC-1:0] word
);
   localparam int COEF_W = BYTE_W * BPC;

   generate
      if (BPC == 1) begin : g_single
         assign word_valid = stb;
         assign word       = din;
      end else begin : g_multi
         localparam int POS_W = $clog2(BPC);
         logic [POS_W-1:0]  pos_q;
         logic [COEF_W-1:0] sh_q;
         logic              last;

         assign last       = (pos_q == POS_W'(BPC - 1));
         assign word_valid = stb && last;
         assign word       = COEF_W'({sh_q, din});

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pos_q <= '0;
               sh_q  <= '0;
            end else if (clr) begin
               pos_q <= '0;
            end else if (stb) begin
               sh_q  <= COEF_W'({sh_q, din});
               pos_q <= last ? '0 : pos_q + 1'b1;
            end
         end

         // R1
         pack_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
            stb && !clr && !last |=> pos_q == $past(pos_q) + 1'b1)
            else $error("byte position did not advance");
      end
   endgenerate
endmodule

// File: rtl/csl_hold_buf.sv
module csl_hold_buf #(
   parameter int W     = 24,
   parameter int DEPTH = 8,
   parameter int IDX_W = 3,
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             wr,
   input  logic [W-1:0]     wdata,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [W-1:0]     rd_data,
   output logic [CNT_W-1:0] fill
);
   logic [W-1:0] mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fill <= '0;
      end else if (clr) begin
         fill <= '0;
      end else if (wr) begin
         fill <= fill + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (wr && !clr) mem[fill[IDX_W-1:0]] <= wdata;
   end

   assign rd_data = mem[rd_idx];

   // R4
   holdbuf_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr |-> fill < CNT_W'(DEPTH))
      else $error("write into a full holding buffer");
endmodule

// File: rtl/csl_commit.sv
module csl_commit #(
   parameter int W      = 24,
   parameter int ADDR_W = 10,
   parameter int IDX_W  = 3,
   parameter int CNT_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              commit_req,
   input  logic [CNT_W-1:0]  fill,
   input  logic [ADDR_W-1:0] base_in,
   output logic              busy,
   output logic [IDX_W-1:0]  rd_idx,
   input  logic [W-1:0]      rd_data,
   output logic              ram_we,
   output logic [ADDR_W-1:0] ram_addr,
   output logic [W-1:0]      ram_wdata
);
   logic              busy_q;
   logic [IDX_W-1:0]  idx_q, last_q;
   logic [ADDR_W-1:0] base_q;
   logic              launch;

   assign launch = commit_req && (fill != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         idx_q  <= '0;
         last_q <= '0;
         base_q <= '0;
      end else if (launch) begin
         busy_q <= 1'b1;
         idx_q  <= '0;
         last_q <= IDX_W'(fill - 1'b1);
         base_q <= base_in;
      end else if (busy_q) begin
         if (idx_q == last_q) busy_q <= 1'b0;
         else                 idx_q  <= idx_q + 1'b1;
      end
   end

   assign busy      = busy_q;
   assign rd_idx    = idx_q;
   assign ram_we    = busy_q;
   assign ram_addr  = base_q + ADDR_W'(idx_q);
   assign ram_wdata = rd_data;

   // R9
   no_commit_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit_req |-> !busy_q)
      else $error("commit requested while busy");

   // R7
   addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q && (idx_q != last_q) |=> busy_q && ram_addr == ADDR_W'($past(ram_addr) + 1'b1))
      else $error("write address did not step by one");

   // R8
   commit_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      launch |=> ram_we && idx_q == '0)
      else $error("commit did not start on the next clock");
endmodule

// File: rtl/coef_stage_loader.sv
module coef_stage_loader #(
   parameter int BYTE_W         = 8,
   parameter int BYTES_PER_COEF = 3,
   parameter int DEPTH          = 8,
   parameter int ADDR_W         = 10
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             bus_start,
   input  logic                             bus_stop,
   input  logic                             byte_valid,
   input  logic [BYTE_W-1:0]                byte_data,
   output logic                             ack_valid,
   output logic                             ack_ok,
   output logic                             busy,
   output logic                             ram_we,
   output logic [ADDR_W-1:0]                ram_addr,
   output logic [BYTE_W*BYTES_PER_COEF-1:0] ram_wdata
);
   localparam int COEF_W = BYTE_W * BYTES_PER_COEF;
   localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNT_W  = $clog2(DEPTH + 1);

   initial begin
      assert (BYTE_W >= 1) else $error("BYTE_W must be at least 1");
      assert (BYTES_PER_COEF >= 1) else $error("BYTES_PER_COEF must be at least 1");
      assert (DEPTH >= 1) else $error("DEPTH must be at least 1");
      assert (ADDR_W >= IDX_W) else $error("ADDR_W too narrow for DEPTH");
   end

   logic              data_stb, clr, commit_req;
   logic [ADDR_W-1:0] base_addr;
   logic              word_valid;
   logic [COEF_W-1:0] word, rd_data;
   logic [IDX_W-1:0]  rd_idx;
   logic [CNT_W-1:0]  fill;

   csl_rx_ctrl #(
      .BYTE_W(BYTE_W), .ADDR_W(ADDR_W), .BPC(BYTES_PER_COEF), .DEPTH(DEPTH)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_stop(bus_stop),
      .byte_valid(byte_valid), .byte_data(byte_data), .busy(busy),
      .ack_valid(ack_valid), .ack_ok(ack_ok), .data_stb(data_stb), .clr(clr),
      .commit_req(commit_req), .base_addr(base_addr)
   );

   csl_word_pack #(.BYTE_W(BYTE_W), .BPC(BYTES_PER_COEF)) u_pack (
      .clk(clk), .rst_n(rst_n), .clr(clr), .stb(data_stb), .din(byte_data),
      .word_valid(word_valid), .word(word)
   );

   csl_hold_buf #(.W(COEF_W), .DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_buf (
      .clk(clk), .rst_n(rst_n), .clr(clr), .wr(word_valid), .wdata(word),
      .rd_idx(rd_idx), .rd_data(rd_data), .fill(fill)
   );

   csl_commit #(.W(COEF_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_commit (
      .clk(clk), .rst_n(rst_n), .commit_req(commit_req), .fill(fill),
      .base_in(base_addr), .busy(busy), .rd_idx(rd_idx), .rd_data(rd_data),
      .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata)
   );

   // R5
   no_write_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
      byte_valid && !busy |=> !ram_we)
      else $error("RAM written during an open transfer");
endmodule

// File: tb/coef_stage_loader_tb.sv
module coef_stage_loader_tb;
   localparam int CLK_PERIOD = 10;
   localparam int BYTE_W = 8;
   localparam int BPC    = 2;
   localparam int DEPTH  = 4;
   localparam int ADDR_W = 10;
   localparam int CW     = BYTE_W * BPC;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              bus_start = 1'b0, bus_stop = 1'b0, byte_valid = 1'b0;
   logic [7:0]        byte_data = '0;
   logic              ack_valid, ack_ok, busy, ram_we;
   logic [ADDR_W-1:0] ram_addr;
   logic [CW-1:0]     ram_wdata;

   int n_chk = 0, n_fail = 0;
   int wn = 0, busy_n = 0;
   logic [ADDR_W-1:0] wa [32];
   logic [CW-1:0]     wd [32];
   logic [CW-1:0]     exp_d [8];

   coef_stage_loader #(
      .BYTE_W(BYTE_W), .BYTES_PER_COEF(BPC), .DEPTH(DEPTH), .ADDR_W(ADDR_W)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_stop(bus_stop),
      .byte_valid(byte_valid), .byte_data(byte_data), .ack_valid(ack_valid),
      .ack_ok(ack_ok), .busy(busy), .ram_we(ram_we), .ram_addr(ram_addr),
      .ram_wdata(ram_wdata)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(negedge clk) begin
      if (rst_n) begin
         if (ram_we) begin
            if (wn < 32) begin
               wa[wn] = ram_addr;
               wd[wn] = ram_wdata;
            end
            wn++;
         end
         if (busy) busy_n++;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string req);
      @(negedge clk);
      byte_valid = 1'b1;
      byte_data  = b;
      @(negedge clk);
      byte_valid = 1'b0;
      chk(ack_valid === 1'b1 && ack_ok === exp_ack, req, "ack",
          {ack_valid, ack_ok}, {1'b1, exp_ack});
   endtask

   task automatic send_addr(input logic [ADDR_W-1:0] a);
      send_byte({6'b0, a[9:8]}, 1'b1, "R2");
      send_byte(a[7:0], 1'b1, "R2");
   endtask

   task automatic send_coef(input logic [CW-1:0] c, input bit exp_ack, input string req);
      send_byte(c[15:8], exp_ack, req);
      send_byte(c[7:0], exp_ack, req);
   endtask

   task automatic pulse_start();
      @(negedge clk); bus_start = 1'b1;
      @(negedge clk); bus_start = 1'b0;
   endtask

   task automatic pulse_stop();
      @(negedge clk); bus_stop = 1'b1;
      @(negedge clk); bus_stop = 1'b0;
   endtask

   task automatic settle();
      repeat (DEPTH + 3) @(negedge clk);
   endtask

   task automatic clear_log();
      @(negedge clk);
      wn = 0;
      busy_n = 0;
   endtask

   task automatic expect_writes(input int n, input logic [ADDR_W-1:0] base, input string req);
      chk(wn == n, "R6", {req, " write count"}, wn, n);
      chk(busy_n == n, "R8", "busy length", busy_n, n);
      for (int i = 0; i < n && i < wn; i++) begin
         chk(wa[i] == ADDR_W'(base + i), "R7", "write address", wa[i], ADDR_W'(base + i));
         chk(wd[i] == exp_d[i], req, "write data", wd[i], exp_d[i]);
      end
   endtask

   task automatic t_reset();
      chk(busy === 1'b0 && ram_we === 1'b0 && ack_valid === 1'b0, "R11", "reset outputs",
          {busy, ram_we, ack_valid}, 0);
   endtask

   task automatic t_stray();
      clear_log();
      send_byte(8'h99, 1'b0, "R10");
      pulse_stop();
      settle();
      chk(wn == 0, "R10", "writes after stray byte", wn, 0);
   endtask

   task automatic t_basic();
      clear_log();
      pulse_start();
      send_addr(10'h005);
      send_coef(16'h1234, 1'b1, "R1");
      send_coef(16'hABCD, 1'b1, "R1");
      repeat (2) @(negedge clk);
      chk(wn == 0, "R5", "writes while open", wn, 0);
      pulse_stop();
      chk(ram_we === 1'b1 && ram_addr == 10'h005, "R8", "first write timing",
          {ram_we, ram_addr}, {1'b1, 10'h005});
      settle();
      exp_d[0] = 16'h1234; exp_d[1] = 16'hABCD;
      expect_writes(2, 10'h005, "R1");
   endtask

   task automatic t_overflow();
      clear_log();
      pulse_start();
      send_addr(10'h100);
      for (int i = 0; i < DEPTH; i++) begin
         exp_d[i] = CW'(16'h1111 * (i + 1));
         send_coef(exp_d[i], 1'b1, "R2");
      end
      send_byte(8'h55, 1'b0, "R3");
      send_byte(8'h66, 1'b0, "R3");
      send_byte(8'h77, 1'b0, "R3");
      pulse_stop();
      settle();
      expect_writes(DEPTH, 10'h100, "R4");
   endtask

   task automatic t_restart_busy();
      clear_log();
      pulse_start();
      send_addr(10'h040);
      for (int i = 0; i < DEPTH; i++) begin
         exp_d[i] = CW'(16'h0A01 + 16'h0101 * i);
         send_coef(exp_d[i], 1'b1, "R2");
      end
      pulse_start();
      chk(ram_we === 1'b1 && ram_addr == 10'h040, "R5", "repeated start commits",
          {ram_we, ram_addr}, {1'b1, 10'h040});
      send_byte(8'h00, 1'b0, "R9");
      send_byte(8'h41, 1'b0, "R9");
      settle();
      send_byte(8'h12, 1'b0, "R9");
      send_byte(8'h34, 1'b0, "R9");
      pulse_stop();
      settle();
      expect_writes(DEPTH, 10'h040, "R9");
   endtask

   task automatic t_partial_latest();
      clear_log();
      pulse_start();
      send_addr(10'h020);
      send_coef(16'h0A0B, 1'b1, "R2");
      send_byte(8'h0C, 1'b1, "R2");
      pulse_stop();
      settle();
      exp_d[0] = 16'h0A0B;
      expect_writes(1, 10'h020, "R6");

      clear_log();
      pulse_start();
      send_addr(10'h2AA);
      pulse_stop();
      settle();
      chk(wn == 0, "R6", "empty transfer writes", wn, 0);

      clear_log();
      pulse_start();
      send_addr(10'h030);
      send_coef(16'h7777, 1'b1, "R2");
      pulse_stop();
      settle();
      exp_d[0] = 16'h7777;
      expect_writes(1, 10'h030, "R6");
   endtask

   task automatic t_wrap();
      clear_log();
      pulse_start();
      send_addr(10'h3FE);
      for (int i = 0; i < 3; i++) begin
         exp_d[i] = CW'(16'h0102 + 16'h0202 * i);
         send_coef(exp_d[i], 1'b1, "R2");
      end
      pulse_stop();
      settle();
      expect_writes(3, 10'h3FE, "R7");
      chk(wn >= 3 && wa[2] == 10'h000, "R7", "wrapped address", wa[2], 0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_stray();
      t_basic();
      t_overflow();
      t_restart_busy();
      t_partial_latest();
      t_wrap();
      repeat (3) @(negedge clk);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule